// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block holds the operating mode of a CAN protocol controller and moves it between five states: Configuration, Normal, Sleep, Loopback and Snoop. It also holds the three-bit mode-select register. Software writes this register. The block clears the sleep bit itself when the controller wakes. The bit-level engine, the frame receiver and the error counters sit around the block and take their steering from its outputs.

The engine and the receiver use four outputs. One forces the transmit pin recessive. One selects the internal loopback path. One enables reception of frames from other nodes. One clears and masks the error counters. The interrupt controller takes a one-cycle pulse when the controller falls asleep and another when it wakes.

All mode changes are registered and happen at the clock edge that follows the causing inputs. A mode-select write reaches the state machine one cycle after it lands in the register.

Top module: `can_mode_seq`

## Requirements
- R1: After reset, and one clock after `enable` is low, `mode` is Configuration. Reset also clears `sel_q` to 0. The mode codes are Configuration=0, Normal=1, Sleep=2, Loopback=3 and Snoop=4.
- R2: From Configuration, with `enable` high and all three `sel_q` bits 0, the next mode is Normal.
- R3: From Normal, the mode becomes Sleep only when three conditions all hold: the sleep bit (`sel_q[2]`) is 1, `bus_idle` is 1, and neither `txfifo_pend` nor `txhp_pend` is set.
- R4: From Configuration, with `enable` high, the loopback bit (`sel_q[0]`) 0 and the snoop bit (`sel_q[1]`) 0, a set sleep bit leads to Sleep when no transmit request is pending. While a request is pending, the mode stays in Configuration.
- R5: In Sleep, `rx_activity` or a pending request from either transmit source moves the mode to Normal at the next edge. The same edge clears `sel_q[2]` to 0, and this clear takes precedence over a write.
- R6: `sleep_irq` is high for exactly the first cycle of each stay in Sleep. `wake_irq` is high for exactly the first Normal cycle after a wake-up. The two are never high together.
- R7: From Configuration with `enable` high, a set loopback bit leads to Loopback. Failing that, a set snoop bit leads to Snoop. When both bits are set, Loopback wins.
- R8: While the mode is Loopback or Snoop and `enable` is high, a write to the mode-select register leaves `sel_q` unchanged.
- R9: The steering outputs decode the mode as follows:
  - `tx_force_recessive` is high in Loopback and in Snoop.
  - `loopback_sel` is high only in Loopback.
  - `errcnt_clear` is high only in Snoop.
  - `rx_ext_en` is high in Normal, Sleep and Snoop, and low in Configuration and Loopback.
- R10: Dropping `enable` while in Sleep returns the mode to Configuration. This raises no interrupt and leaves the sleep bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Controller enable |
| sel_wr | input | 1 | Write strobe for the mode-select register |
| sel_wdata | input | 3 | Write data: bit 0 loopback, bit 1 snoop, bit 2 sleep |
| bus_idle | input | 1 | CAN bus is idle |
| txfifo_pend | input | 1 | TX FIFO holds a pending request |
| txhp_pend | input | 1 | High-priority TX buffer holds a pending request |
| rx_activity | input | 1 | A frame from another node is being detected |
| mode | output | 3 | Current mode code |
| sel_q | output | 3 | Mode-select register contents |
| tx_force_recessive | output | 1 | Force the transmit pin recessive |
| loopback_sel | output | 1 | Route transmit frames internally to receive |
| rx_ext_en | output | 1 | Accept frames from other nodes |
| errcnt_clear | output | 1 | Hold the error counters at zero |
| sleep_irq | output | 1 | One-cycle pulse on entry to Sleep |
| wake_irq | output | 1 | One-cycle pulse on wake-up |

## Verification
The bench first tries to fall asleep while a transmit request is pending or the bus is busy. A design that checked only the sleep bit would sleep with a frame waiting and lose it.

The bench wakes the controller once through bus traffic and once through the high-priority buffer. After each wake it checks that the sleep bit reads back 0. A design that kept the bit set would drop straight back into Sleep.

The bench sets both diagnostic bits at once, then writes while in each diagnostic mode. A wrong priority would enter Snoop. A missing write lock would alter the register behind the engine's back.

It also drops `enable` in Sleep and resets in mid-run. A design that raised a wake pulse on the way out, or kept stale register bits after reset, would show it at the outputs.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

   typedef enum logic [2:0] {
      MODE_CONFIG   = 3'd0,
      MODE_NORMAL   = 3'd1,
      MODE_SLEEP    = 3'd2,
      MODE_LOOPBACK = 3'd3,
      MODE_SNOOP    = 3'd4
   } can_mode_e;

   localparam int SEL_LOOP  = 0;
   localparam int SEL_SNOOP = 1;
   localparam int SEL_SLEEP = 2;
   localparam int SEL_MIN_W = 3;

endpackage

// File: rtl/can_mode_sel_reg.sv
module can_mode_sel_reg
   import can_mode_pkg::*;
#(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [SEL_W-1:0] wdata,
   input  logic             lock,
   input  logic             hw_clr_sleep,
   output logic [SEL_W-1:0] sel_q
);

   if (SEL_W < SEL_MIN_W) begin : g_bad_width
      $error("can_mode_sel_reg: SEL_W must be at least 3");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else begin
         if (wr && !lock) sel_q <= wdata;
         if (hw_clr_sleep) sel_q[SEL_SLEEP] <= 1'b0;
      end
   end

   // R8: a locked write leaves the register untouched
   a_r8_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !hw_clr_sleep) |=> $stable(sel_q));

   // R5: a wake request clears the sleep bit even when a write sets it
   a_r5_hw_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      hw_clr_sleep |=> !sel_q[SEL_SLEEP]);

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
   import can_mode_pkg::*;
#(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [SEL_W-1:0] sel_q,
   input  logic             bus_idle,
   input  logic             tx_pend,
   input  logic             rx_activity,
   output can_mode_e        state,
   output logic             hw_clr_sleep,
   output logic             sleep_irq,
   output logic             wake_irq
);

   can_mode_e nxt;
   logic      wake_req;

   assign wake_req     = rx_activity || tx_pend;
   assign hw_clr_sleep = enable && (state == MODE_SLEEP) && wake_req;

   always_comb begin
      nxt = state;
      unique case (state)
         MODE_CONFIG: begin
            if (sel_q[SEL_LOOP])        nxt = MODE_LOOPBACK;
            else if (sel_q[SEL_SNOOP])  nxt = MODE_SNOOP;
            else if (sel_q[SEL_SLEEP]) begin
               if (!tx_pend)            nxt = MODE_SLEEP;
            end else                    nxt = MODE_NORMAL;
         end
         MODE_NORMAL: begin
            if (sel_q[SEL_SLEEP] && bus_idle && !tx_pend) nxt = MODE_SLEEP;
         end
         MODE_SLEEP: begin
            if (wake_req) nxt = MODE_NORMAL;
         end
         default: nxt = state;
      endcase
      if (!enable) nxt = MODE_CONFIG;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= MODE_CONFIG;
         sleep_irq <= 1'b0;
         wake_irq  <= 1'b0;
      end else begin
         state     <= nxt;
         sleep_irq <= (nxt == MODE_SLEEP) && (state != MODE_SLEEP);
         wake_irq  <= (state == MODE_SLEEP) && (nxt == MODE_NORMAL);
      end
   end

   // R1: a low enable forces Configuration at the next edge
   a_r1_disable_to_config: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> state == MODE_CONFIG);

   // R3: no sleep while a transmit request is pending
   a_r3_pending_blocks_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      (state == MODE_NORMAL && tx_pend) |=> state != MODE_SLEEP);

   // R6: sleep pulse only in the first sleep cycle
   a_r6_sleep_pulse_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_irq |-> (state == MODE_SLEEP && $past(state) != MODE_SLEEP));

   // R6: the two interrupt pulses never coincide
   a_r6_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(sleep_irq && wake_irq));

   // R5: a wake pulse lands in Normal
   a_r5_wake_to_normal: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |-> state == MODE_NORMAL);

endmodule

// File: rtl/can_mode_decode.sv
module can_mode_decode
   import can_mode_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  can_mode_e state,
   output logic      tx_force_recessive,
   output logic      loopback_sel,
   output logic      rx_ext_en,
   output logic      errcnt_clear
);

   logic d_rec, d_loop, d_rx, d_clr;

   always_comb begin
      d_rec  = (state == MODE_LOOPBACK) || (state == MODE_SNOOP);
      d_loop = (state == MODE_LOOPBACK);
      d_rx   = (state == MODE_NORMAL) || (state == MODE_SLEEP) || (state == MODE_SNOOP);
      d_clr  = (state == MODE_SNOOP);
   end

   if (REG_OUT) begin : g_registered
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tx_force_recessive <= 1'b0;
            loopback_sel       <= 1'b0;
            rx_ext_en          <= 1'b0;
            errcnt_clear       <= 1'b0;
         end else begin
            tx_force_recessive <= d_rec;
            loopback_sel       <= d_loop;
            rx_ext_en          <= d_rx;
            errcnt_clear       <= d_clr;
         end
      end
   end else begin : g_direct
      assign tx_force_recessive = d_rec;
      assign loopback_sel       = d_loop;
      assign rx_ext_en          = d_rx;
      assign errcnt_clear       = d_clr;

      // R9: loopback never listens to other nodes
      a_r9_loopback_deaf: assert property (@(posedge clk) disable iff (!rst_n)
         loopback_sel |-> (!rx_ext_en && tx_force_recessive));
   end

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
   import can_mode_pkg::*;
#(
   parameter int SEL_W   = 3,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             sel_wr,
   input  logic [SEL_W-1:0] sel_wdata,
   input  logic             bus_idle,
   input  logic             txfifo_pend,
   input  logic             txhp_pend,
   input  logic             rx_activity,
   output logic [2:0]       mode,
   output logic [SEL_W-1:0] sel_q,
   output logic             tx_force_recessive,
   output logic             loopback_sel,
   output logic             rx_ext_en,
   output logic             errcnt_clear,
   output logic             sleep_irq,
   output logic             wake_irq
);

   localparam int MODE_W = $bits(can_mode_e);

   if (MODE_W != 3) begin : g_bad_mode_w
      $error("can_mode_seq: mode code must be 3 bits");
   end

   can_mode_e state;
   logic      tx_pend, hw_clr_sleep, diag_lock;

   assign tx_pend   = txfifo_pend || txhp_pend;
   assign diag_lock = enable && ((state == MODE_LOOPBACK) || (state == MODE_SNOOP));
   assign mode      = state;

   can_mode_sel_reg #(.SEL_W(SEL_W)) u_sel (
      .clk(clk), .rst_n(rst_n), .wr(sel_wr), .wdata(sel_wdata),
      .lock(diag_lock), .hw_clr_sleep(hw_clr_sleep), .sel_q(sel_q)
   );

   can_mode_fsm #(.SEL_W(SEL_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .enable(enable), .sel_q(sel_q),
      .bus_idle(bus_idle), .tx_pend(tx_pend), .rx_activity(rx_activity),
      .state(state), .hw_clr_sleep(hw_clr_sleep),
      .sleep_irq(sleep_irq), .wake_irq(wake_irq)
   );

   can_mode_decode #(.REG_OUT(REG_OUT)) u_dec (
      .clk(clk), .rst_n(rst_n), .state(state),
      .tx_force_recessive(tx_force_recessive), .loopback_sel(loopback_sel),
      .rx_ext_en(rx_ext_en), .errcnt_clear(errcnt_clear)
   );

   // R10: leaving sleep by disable raises no wake pulse
   a_r10_disable_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (state == MODE_SLEEP && !enable) |=> !wake_irq);

endmodule

// File: tb/can_mode_seq_test.sv
module can_mode_seq_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0, sel_wr = 1'b0;
   logic [2:0] sel_wdata = 3'b000;
   logic       bus_idle = 1'b0, txfifo_pend = 1'b0, txhp_pend = 1'b0, rx_activity = 1'b0;
   logic [2:0] mode, sel_q;
   logic       tx_force_recessive, loopback_sel, rx_ext_en, errcnt_clear, sleep_irq, wake_irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   can_mode_seq uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
      .bus_idle(bus_idle), .txfifo_pend(txfifo_pend), .txhp_pend(txhp_pend),
      .rx_activity(rx_activity), .mode(mode), .sel_q(sel_q),
      .tx_force_recessive(tx_force_recessive), .loopback_sel(loopback_sel),
      .rx_ext_en(rx_ext_en), .errcnt_clear(errcnt_clear),
      .sleep_irq(sleep_irq), .wake_irq(wake_irq)
   );

   // row: [16]en [15]wr [14:12]wdata [11]idle [10]fifo [9]hp [8]rx
   //      [7:5]mode [4]sleep_irq [3]wake_irq [2:0]sel_q   (all expected after one edge)
   localparam int NV = 27;
   localparam logic [16:0] VEC [0:NV-1] = '{
      {1'b0,1'b0,3'b000,1'b0,1'b0,1'b0,1'b0, 3'd0,1'b0,1'b0,3'b000}, // R1 disabled
      {1'b1,1'b0,3'b000,1'b0,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b0,3'b000}, // R2 to Normal
      {1'b1,1'b1,3'b100,1'b1,1'b1,1'b0,1'b0, 3'd1,1'b0,1'b0,3'b100}, // write sleep
      {1'b1,1'b0,3'b000,1'b1,1'b1,1'b0,1'b0, 3'd1,1'b0,1'b0,3'b100}, // R3 pending blocks
      {1'b1,1'b0,3'b000,1'b0,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b0,3'b100}, // R3 busy bus blocks
      {1'b1,1'b0,3'b000,1'b1,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,3'b100}, // R3 R6 sleep
      {1'b1,1'b0,3'b000,1'b1,1'b0,1'b0,1'b0, 3'd2,1'b0,1'b0,3'b100}, // R6 pulse ends
      {1'b1,1'b0,3'b000,1'b1,1'b0,1'b0,1'b1, 3'd1,1'b0,1'b1,3'b000}, // R5 rx wake
      {1'b1,1'b0,3'b000,1'b1,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b0,3'b000}, // R5 stays awake
      {1'b1,1'b1,3'b100,1'b0,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b0,3'b100},
      {1'b1,1'b0,3'b000,1'b1,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,3'b100}, // R6
      {1'b1,1'b1,3'b100,1'b1,1'b0,1'b1,1'b0, 3'd1,1'b0,1'b1,3'b000}, // R5 hp wake, clear wins
      {1'b0,1'b0,3'b000,1'b0,1'b0,1'b0,1'b0, 3'd0,1'b0,1'b0,3'b000}, // R1
      {1'b0,1'b1,3'b011,1'b0,1'b0,1'b0,1'b0, 3'd0,1'b0,1'b0,3'b011},
      {1'b1,1'b0,3'b000,1'b0,1'b0,1'b0,1'b0, 3'd3,1'b0,1'b0,3'b011}, // R7 loopback wins
      {1'b1,1'b1,3'b000,1'b0,1'b0,1'b0,1'b1, 3'd3,1'b0,1'b0,3'b011}, // R8 write ignored
      {1'b0,1'b0,3'b000,1'b0,1'b0,1'b0,1'b0, 3'd0,1'b0,1'b0,3'b011}, // R1
      {1'b0,1'b1,3'b010,1'b0,1'b0,1'b0,1'b0, 3'd0,1'b0,1'b0,3'b010},
      {1'b1,1'b0,3'b000,1'b0,1'b0,1'b0,1'b0, 3'd4,1'b0,1'b0,3'b010}, // R7 snoop
      {1'b1,1'b1,3'b000,1'b1,1'b0,1'b0,1'b0, 3'd4,1'b0,1'b0,3'b010}, // R8 write ignored
      {1'b0,1'b1,3'b100,1'b0,1'b1,1'b0,1'b0, 3'd0,1'b0,1'b0,3'b100},
      {1'b1,1'b0,3'b000,1'b0,1'b1,1'b0,1'b0, 3'd0,1'b0,1'b0,3'b100}, // R4 pending holds
      {1'b1,1'b0,3'b000,1'b0,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,3'b100}, // R4 config to sleep
      {1'b0,1'b0,3'b000,1'b0,1'b0,1'b0,1'b1, 3'd0,1'b0,1'b0,3'b100}, // R10
      {1'b0,1'b1,3'b000,1'b0,1'b0,1'b0,1'b0, 3'd0,1'b0,1'b0,3'b000},
      {1'b1,1'b0,3'b000,1'b0,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b0,3'b000}, // R2
      {1'b1,1'b0,3'b000,1'b1,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b0,3'b000}
   };

   task automatic check(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_decode(input string req, input logic [2:0] m);
      check(req, "tx_force_recessive", int'(tx_force_recessive), int'(m == 3'd3 || m == 3'd4));
      check(req, "loopback_sel", int'(loopback_sel), int'(m == 3'd3));
      check(req, "errcnt_clear", int'(errcnt_clear), int'(m == 3'd4));
      check(req, "rx_ext_en", int'(rx_ext_en), int'(m == 3'd1 || m == 3'd2 || m == 3'd4));
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "mode in reset", int'(mode), 0);
      check("R1", "sel_q in reset", int'(sel_q), 0);
      check("R6", "irqs in reset", int'({sleep_irq, wake_irq}), 0);
      check_decode("R9", 3'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         {enable, sel_wr, sel_wdata, bus_idle, txfifo_pend, txhp_pend, rx_activity} = VEC[i][16:8];
         @(posedge clk);
         @(negedge clk);
         check("R1-R8 row", "mode", int'(mode), int'(VEC[i][7:5]));
         check("R6 row", "sleep_irq", int'(sleep_irq), int'(VEC[i][4]));
         check("R6 row", "wake_irq", int'(wake_irq), int'(VEC[i][3]));
         check("R8 row", "sel_q", int'(sel_q), int'(VEC[i][2:0]));
         check_decode("R9 row", VEC[i][7:5]);
      end

      // R1: reset in mid-run clears mode and register
      sel_wr = 1'b1; sel_wdata = 3'b100; bus_idle = 1'b0;
      @(posedge clk); @(negedge clk);
      sel_wr = 1'b0;
      rst_n = 1'b0;
      #1;
      check("R1", "mode after mid-run reset", int'(mode), 0);
      check("R1", "sel_q after mid-run reset", int'(sel_q), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R2", "mode after reset release", int'(mode), 1);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule